// File: doc/BRIEF.md
# Service Request Handshake Controller

This block raises an active-low service request towards a host processor on behalf of two request sources of a parallel port channel: a port source and a pipeline source. The host answers either with a hardware acknowledge strobe or by polling the block's registers. After a request has been served, the block stays locked until the host closes the service context. Closing is done by a write to an end-of-service address, by clearing the pending bit directly, or by toggling the interrupt-enable bit.

The host reaches four byte-wide registers on a simple bus. Writes take one cycle and reads are combinational. The status register holds the pending bit and the sources of the open context. The vector register holds an identification code that is loaded on a hardware acknowledge. The control register holds the enable bit. The fourth address is a write-only end-of-service strobe. Source events that arrive while a context is open are held and raised once the context closes.

Top module: `srq_top`

## Requirements
- R1: Asynchronous reset (rst_ni low) clears the status, vector and control registers and drives req_no high, both at start-up and in the middle of operation.
- R2: A source event (port_evt_i, pipe_evt_i) is recorded at the clock edge where it is seen. If control bit 4 (enable) is set and no context is open, req_no goes low at the next edge. Status then reads bit 7 = 1 (pending), bit 0 = port and bit 1 = pipeline.
- R3: ack_i while req_no is low drives req_no high at the next edge and loads the vector with 0x21 when the port source is in the context (port has priority) and 0x22 otherwise. ack_i while req_no is high has no effect.
- R4: After an acknowledge, req_no stays high until the context is closed. Events that arrive in the meantime are held and raise req_no at the first edge after the close.
- R5: A write to address 3 (end of service), with any data, closes the context: status reads 0x00, the vector reads 0x00 and req_no goes high. This holds before or after an acknowledge.
- R6: A write to address 2 stores the byte. If it changes bit 4, it closes the context. A write that leaves bit 4 unchanged does not. While bit 4 is 0, no request is raised and events stay held until bit 4 is set again.
- R7: A write to address 0 with bit 7 = 0 closes the context at any time, including before an acknowledge. A write to address 0 with bit 7 = 1 has no effect.
- R8: A read of address 0 returns status, address 1 returns the vector, address 2 returns the stored control byte, and address 3 returns 0x00.
- R9: When a close and an acknowledge fall in the same cycle, the close wins: the vector reads 0x00 and req_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_evt_i | input | 1 | Port source needs service (one-cycle event) |
| pipe_evt_i | input | 1 | Pipeline source needs service (one-cycle event) |
| ack_i | input | 1 | Hardware acknowledge strobe from the host I/O cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| req_no | output | 1 | Service request to the host, active low |

## Verification
A pending bit stuck high would keep req_no high forever after the first close, so it shows as a missing request two edges after the next event. A lost held event shows the same way: req_no would not fall at the first edge after a close. A wrong vector or missed source priority shows in the vector read one edge after the acknowledge. A missed close shows in the status read at the edge that follows the end-of-service, direct-clear or enable-toggle write.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int DW       = 8;
  localparam int AW       = 2;
  localparam int NSRC     = 2;
  localparam int EN_BIT   = 4;
  localparam int PEND_BIT = 7;
  localparam logic [DW-1:0] VEC_PORT = 8'h21;
  localparam logic [DW-1:0] VEC_PIPE = 8'h22;

  typedef enum logic [AW-1:0] {
    A_STAT = 2'd0,
    A_VEC  = 2'd1,
    A_CTRL = 2'd2,
    A_EOS  = 2'd3
  } srq_addr_e;
endpackage

// File: rtl/srq_decode.sv
module srq_decode
  import srq_pkg::*;
(
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wd_pend_i,
  input  logic          wd_en_i,
  input  logic          en_q_i,
  output logic          ctrl_wr_o,
  output logic          close_o
);
  logic eos_wr, stat_clr, toggle;

  always_comb begin
    eos_wr    = we_i && (addr_i == A_EOS);
    stat_clr  = we_i && (addr_i == A_STAT) && !wd_pend_i;
    ctrl_wr_o = we_i && (addr_i == A_CTRL);
    toggle    = ctrl_wr_o && (wd_en_i != en_q_i);
    close_o   = eos_wr || stat_clr || toggle;
  end
endmodule

// File: rtl/srq_src_latch.sv
module srq_src_latch
  import srq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            take_i,
  output logic [NSRC-1:0] wait_o
);
  logic [NSRC-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= '0;
    else         wait_q <= (take_i ? '0 : wait_q) | evt_i;
  end
  assign wait_o = wait_q;

  // R4: held events are never dropped without being taken
  a_r4_hold_events: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && (wait_q != '0)) |=> (wait_o != '0));
endmodule

// File: rtl/srq_ctx.sv
module srq_ctx
  import srq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ack_i,
  input  logic            close_i,
  input  logic            ctrl_wr_i,
  input  logic [DW-1:0]   ctrl_wd_i,
  input  logic [NSRC-1:0] wait_i,
  output logic            take_o,
  output logic [DW-1:0]   ctrl_o,
  output logic            pend_o,
  output logic [NSRC-1:0] act_o,
  output logic [DW-1:0]   vec_o,
  output logic            req_no
);
  logic [DW-1:0]   ctrl_q;
  logic            pend_q, req_nq;
  logic [NSRC-1:0] act_q;
  logic [DW-1:0]   vec_q;
  logic            issue, ack_hit;

  assign issue   = ctrl_q[EN_BIT] && !pend_q && (wait_i != '0) && !close_i;
  assign ack_hit = ack_i && !req_nq;
  assign take_o  = issue;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      act_q  <= '0;
      vec_q  <= '0;
      req_nq <= 1'b1;
    end else begin
      if (ctrl_wr_i) ctrl_q <= ctrl_wd_i;
      if (close_i) begin
        pend_q <= 1'b0;
        act_q  <= '0;
        vec_q  <= '0;
        req_nq <= 1'b1;
      end else if (issue) begin
        pend_q <= 1'b1;
        act_q  <= wait_i;
        req_nq <= 1'b0;
      end else if (ack_hit) begin
        req_nq <= 1'b1;
        vec_q  <= act_q[0] ? VEC_PORT : VEC_PIPE;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign vec_o  = vec_q;
  assign req_no = req_nq;

  // R2: an active request always belongs to an open context
  a_r2_req_has_ctx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_no |-> pend_o);
  // R3: acknowledge removes the request
  a_r3_ack_drops_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_no) |=> req_no);
  // R4: no new request while an acknowledged context is open
  a_r4_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && req_no) |=> req_no);
  // R5: any close clears vector and pending
  a_r5_close_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> (vec_o == '0 && !pend_o && req_no));
  // R6: disabled block never raises a request
  a_r6_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[EN_BIT] && req_no) |=> req_no);
  // R9: close beats a simultaneous acknowledge
  a_r9_close_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && ack_i) |=> (vec_o == '0));
endmodule

// File: rtl/srq_top.sv
module srq_top
  import srq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          port_evt_i,
  input  logic          pipe_evt_i,
  input  logic          ack_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          req_no
);
  logic            ctrl_wr, close, take, pend;
  logic [NSRC-1:0] wait_s, act;
  logic [DW-1:0]   ctrl, vec;

  srq_decode i_decode (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wd_pend_i (reg_wdata_i[PEND_BIT]),
    .wd_en_i   (reg_wdata_i[EN_BIT]),
    .en_q_i    (ctrl[EN_BIT]),
    .ctrl_wr_o (ctrl_wr),
    .close_o   (close)
  );

  srq_src_latch i_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  ({pipe_evt_i, port_evt_i}),
    .take_i (take),
    .wait_o (wait_s)
  );

  srq_ctx i_ctx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (ack_i),
    .close_i   (close),
    .ctrl_wr_i (ctrl_wr),
    .ctrl_wd_i (reg_wdata_i),
    .wait_i    (wait_s),
    .take_o    (take),
    .ctrl_o    (ctrl),
    .pend_o    (pend),
    .act_o     (act),
    .vec_o     (vec),
    .req_no    (req_no)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (srq_addr_e'(reg_addr_i))
      A_STAT: begin
        reg_rdata_o[PEND_BIT]  = pend;
        reg_rdata_o[NSRC-1:0]  = act;
      end
      A_VEC:  reg_rdata_o = vec;
      A_CTRL: reg_rdata_o = ctrl;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/test_srq_top.sv
`timescale 1ns/1ps
module test_srq_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       port_evt = 1'b0, pipe_evt = 1'b0, ack = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic       req_n;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  srq_top i_srq_top (
    .clk_i(clk), .rst_ni(rst_ni), .port_evt_i(port_evt), .pipe_evt_i(pipe_evt),
    .ack_i(ack), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .req_no(req_n)
  );

  typedef struct packed {
    logic       port, pipe, ack, we;
    logic [1:0] addr;
    logic [7:0] wd;
    logic       rn;
    logic [7:0] st, vc;
    logic [3:0] rid;
  } row_t;

  localparam int NROW = 25;
  localparam row_t TBL [NROW] = '{
    '{0,0,0,1,2'd2,8'h10,1,8'h00,8'h00,4'd6}, // R6 enable
    '{1,0,0,0,2'd0,8'h00,1,8'h00,8'h00,4'd2}, // R2 port event
    '{0,0,0,0,2'd0,8'h00,0,8'h81,8'h00,4'd2}, // R2 raise
    '{0,0,1,0,2'd0,8'h00,1,8'h81,8'h21,4'd3}, // R3 ack port
    '{0,1,0,0,2'd0,8'h00,1,8'h81,8'h21,4'd4}, // R4 held
    '{0,0,0,0,2'd0,8'h00,1,8'h81,8'h21,4'd4}, // R4 locked
    '{0,0,0,1,2'd3,8'hFF,1,8'h00,8'h00,4'd5}, // R5 eos
    '{0,0,0,0,2'd0,8'h00,0,8'h82,8'h00,4'd4}, // R4 re-raise
    '{0,0,1,0,2'd0,8'h00,1,8'h82,8'h22,4'd3}, // R3 ack pipe
    '{0,0,0,1,2'd0,8'h00,1,8'h00,8'h00,4'd7}, // R7 clear
    '{1,1,0,0,2'd0,8'h00,1,8'h00,8'h00,4'd2}, // R2 both
    '{0,0,0,0,2'd0,8'h00,0,8'h83,8'h00,4'd2}, // R2
    '{0,0,1,0,2'd0,8'h00,1,8'h83,8'h21,4'd3}, // R3 priority
    '{0,0,0,1,2'd2,8'h00,1,8'h00,8'h00,4'd6}, // R6 toggle off
    '{1,0,0,0,2'd0,8'h00,1,8'h00,8'h00,4'd6}, // R6
    '{0,0,0,0,2'd0,8'h00,1,8'h00,8'h00,4'd6}, // R6 disabled
    '{0,0,0,1,2'd2,8'h10,1,8'h00,8'h00,4'd6}, // R6 toggle on
    '{0,0,0,0,2'd0,8'h00,0,8'h81,8'h00,4'd6}, // R6 raise held
    '{0,0,0,1,2'd0,8'h00,1,8'h00,8'h00,4'd7}, // R7 early clear
    '{0,0,1,0,2'd0,8'h00,1,8'h00,8'h00,4'd3}, // R3 stray ack
    '{0,1,0,0,2'd0,8'h00,1,8'h00,8'h00,4'd2}, // R2
    '{0,0,0,0,2'd0,8'h00,0,8'h82,8'h00,4'd2}, // R2
    '{0,0,0,1,2'd2,8'h10,0,8'h82,8'h00,4'd6}, // R6 no toggle
    '{0,0,0,1,2'd0,8'h80,0,8'h82,8'h00,4'd7}, // R7 bit7=1 ignored
    '{0,0,0,1,2'd3,8'h00,1,8'h00,8'h00,4'd5}  // R5 eos before ack
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(input logic p, input logic q, input logic k, input logic w,
                     input logic [1:0] a, input logic [7:0] d);
    port_evt = p; pipe_evt = q; ack = k; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    port_evt = 0; pipe_evt = 0; ack = 0; we = 0;
  endtask

  task automatic look(input string tag, input logic rn, input logic [7:0] st, input logic [7:0] vc);
    logic [7:0] d;
    chk({tag, " req_no"}, {7'd0, req_n}, {7'd0, rn});
    rd(2'd0, d); chk({tag, " status"}, d, st);
    rd(2'd1, d); chk({tag, " vector"}, d, vc);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1;
    look("R1 reset", 1'b1, 8'h00, 8'h00);
    rd(2'd2, d); chk("R1 reset ctrl", d, 8'h00);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NROW; i++) begin
      cyc(TBL[i].port, TBL[i].pipe, TBL[i].ack, TBL[i].we, TBL[i].addr, TBL[i].wd);
      look($sformatf("R%0d row%0d", TBL[i].rid, i), TBL[i].rn, TBL[i].st, TBL[i].vc);
    end

    // R8 register reads
    rd(2'd2, d); chk("R8 ctrl read", d, 8'h10);
    cyc(0,0,0,1,2'd2,8'h5A);
    rd(2'd2, d); chk("R8 ctrl byte", d, 8'h5A);
    rd(2'd3, d); chk("R8 eos read", d, 8'h00);
    cyc(0,0,0,1,2'd2,8'h10);

    // R9 close and ack together
    cyc(1,0,0,0,2'd0,8'h00);
    cyc(0,0,0,0,2'd0,8'h00);
    look("R9 raised", 1'b0, 8'h81, 8'h00);
    cyc(0,0,1,1,2'd3,8'h00);
    look("R9 close wins", 1'b1, 8'h00, 8'h00);

    // R1 reset mid-run
    cyc(0,1,0,0,2'd0,8'h00);
    cyc(0,0,0,0,2'd0,8'h00);
    look("R1 pre-reset", 1'b0, 8'h82, 8'h00);
    rst_ni = 1'b0;
    #2;
    look("R1 mid reset", 1'b1, 8'h00, 8'h00);
    rd(2'd2, d); chk("R1 mid reset ctrl", d, 8'h00);
    @(posedge clk); #1 rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule